// File: doc/BRIEF.md
# Compressed register-form ALU decoder

This block is a purely combinational decoder for the two-register integer, logical and floating-point forms of a 16-bit compressed instruction encoding. It takes one 16-bit instruction word and a flag that says whether the fetch stream is in the narrow (10-bit payload) mode or the full 16-bit mode. It returns a micro-operation code and the three register indices. It also returns a flag that replaces the first source with the constant zero, the condition-register field the operation updates, and flags for an illegal word and for a no-operation.

Only the register-form major opcodes 010 to 110 are decoded here. Words whose major opcode is 000, 001 or 111 are left to other decoders. The block reports no operation for them and does not call them illegal, unless the word is all zeros. The narrow mode sees only the low eleven bits of the word. In that mode the destination is the second source register, and the second opcode page is not available. In 16-bit mode the top bits carry an explicit destination field and a page-select bit.

Top module: `c16_alu_decode`

## Requirements
- R1: Field positions are fixed: M = insn[0], RA = insn[3:1], RB = insn[6:4], opcode = insn[10:7] (major insn[10:8], minor insn[7]), RT = insn[13:11], page = insn[14], N = insn[15]. Output `rb` is always RB. Output `rd` is RT in 16-bit mode (`mode16`=1) and RB in 10-bit mode. Output `ra` is RA, except for srad, where it is RT.
- R2: Micro-operation codes: none 0, add 1, sub 2, cmpl 3, cmpw 4, sld 5, srd 6, srad 7, and 8, nand 9, or 10, nor 11, mr 12, not 13, extsw 14, extsb 15, extsh 16, cntlz 17, cnttz 18, popcnt 19, xor 20, eqv 21, fadd 22, fsub 23, fmul 24, fdiv 25, fneg 26, fabs 27, fmr 28, bank-select 29.
- R3: On page 0, opcode 0100 is add when RA is nonzero and bank-select when RA is zero. Opcode 0101 is sub and opcode 0110 is cmpl.
- R4: On page 0 with RA nonzero: opcode 1000 is and, 1001 is nand and 1010 is or. Opcode 1011 is nor in 16-bit mode and mr in 10-bit mode.
- R5: On page 0 with RA zero: opcode 1011 is not in both modes. Opcodes 1000, 1001 and 1010 are extsw, cntlz and popcnt in 16-bit mode, and illegal in 10-bit mode.
- R6: Page 1 is selected only when `mode16`=1 and insn[14]=1. In 10-bit mode insn[14] has no effect. On page 1 the logical slots decode as follows. With RA nonzero: 1010 is xor, 1011 is eqv, and 1000 and 1001 are reserved. With RA zero: 1000 is extsb, 1001 is cnttz, 1011 is extsh, and 1010 is reserved.
- R7: On page 1, opcode 0100 is sld and opcode 0110 is cmpw. Opcode 0101 is srad when RA is zero and srd otherwise.
- R8: On page 0: 1100 is fadd and 1101 is fmul when RA is nonzero, and both are reserved when RA is zero. 0111 is fsub when RA is nonzero and fneg when RA is zero. On page 1: 1101 is fdiv when RA is nonzero, 0111 is fabs when RA is zero, and 1100 is fmr when RA is zero. Every other page-1 floating slot is reserved.
- R9: `zero_a` is 1 exactly when RA is zero and the decoded operation is one other than none, srad and bank-select.
- R10: `cr_tgt` codes are 0 none, 1 CR0 and 2 CR1. CR0 goes with sub, cmpl, cmpw, sld, srd and srad. CR1 goes with fsub, fneg, fabs and fmr. Every other operation reports none.
- R11: `illegal` is 1 for the all-zero word in either mode and for every reserved or mode-unavailable slot. When `illegal` is 1, `uop`, `zero_a` and `cr_tgt` are 0.
- R12: `nop` is 1 for the word 0x0001 in either mode. It is also 1 for 0x8000 and 0x8001 in 16-bit mode. A nop is never illegal.
- R13: Opcodes 0000 to 0011 and 1110 to 1111 give `uop` 0 and `illegal` 0, except for the all-zero word. In 10-bit mode, insn[15:11] has no effect on any output for words whose low eleven bits are neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode16 | input | 1 | 1 = full 16-bit mode, 0 = narrow 10-bit mode |
| insn | input | 16 | instruction word |
| uop | output | 5 | micro-operation code (R2) |
| rd | output | 3 | destination register index |
| ra | output | 3 | first source register index |
| rb | output | 3 | second source register index |
| zero_a | output | 1 | first source reads constant zero |
| cr_tgt | output | 2 | condition field updated (0 none, 1 CR0, 2 CR1) |
| illegal | output | 1 | word is illegal in the current mode |
| nop | output | 1 | word is a no-operation |

## Verification
A vector table covers every opcode and page slot with RA set to zero and to a nonzero value. This separates the binary operations from their unary or zero-operand twins, and separates legal slots from reserved ones. The same bit patterns are applied in both modes. This shows the nor/mr split, the narrow-mode loss of the extends and counts, the ignored page bit and the moving destination field. The all-zero word, the three nop words and out-of-scope majors are applied directly. A sweep in narrow mode varies the five top bits under fixed low bits to show that those bits are ignored.

// File: rtl/c16_alu_pkg.sv
package c16_alu_pkg;
  localparam int INSN_W = 16;
  localparam int REG_W  = 3;
  localparam int OPC_W  = 4;
  localparam int UOP_W  = 5;

  // field least-significant positions inside the instruction word
  localparam int POS_RA   = 1;
  localparam int POS_RB   = POS_RA + REG_W;
  localparam int POS_OPC  = POS_RB + REG_W;
  localparam int POS_RT   = POS_OPC + OPC_W;
  localparam int POS_PAGE = POS_RT + REG_W;

  typedef enum logic [UOP_W-1:0] {
    UOP_NONE  = 5'd0,  UOP_ADD   = 5'd1,  UOP_SUB   = 5'd2,  UOP_CMPL  = 5'd3,
    UOP_CMPW  = 5'd4,  UOP_SLD   = 5'd5,  UOP_SRD   = 5'd6,  UOP_SRAD  = 5'd7,
    UOP_AND   = 5'd8,  UOP_NAND  = 5'd9,  UOP_OR    = 5'd10, UOP_NOR   = 5'd11,
    UOP_MR    = 5'd12, UOP_NOT   = 5'd13, UOP_EXTSW = 5'd14, UOP_EXTSB = 5'd15,
    UOP_EXTSH = 5'd16, UOP_CNTLZ = 5'd17, UOP_CNTTZ = 5'd18, UOP_POPCNT= 5'd19,
    UOP_XOR   = 5'd20, UOP_EQV   = 5'd21, UOP_FADD  = 5'd22, UOP_FSUB  = 5'd23,
    UOP_FMUL  = 5'd24, UOP_FDIV  = 5'd25, UOP_FNEG  = 5'd26, UOP_FABS  = 5'd27,
    UOP_FMR   = 5'd28, UOP_CBANK = 5'd29
  } uop_e;

  typedef enum logic [1:0] {
    CRT_NONE = 2'd0,
    CRT_CR0  = 2'd1,
    CRT_CR1  = 2'd2
  } crt_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rb;
    logic [REG_W-1:0] ra;
  } fields_t;
endpackage

// File: rtl/c16_fields.sv
module c16_fields
  import c16_alu_pkg::*;
(
  input  logic              mode16_i,
  input  logic [INSN_W-2:1] body_i,
  output fields_t           f_o,
  output logic [REG_W-1:0]  dest_o,
  output logic              page_o,
  output logic              ra_zero_o
);
  always_comb begin
    f_o.ra  = body_i[POS_RA  +: REG_W];
    f_o.rb  = body_i[POS_RB  +: REG_W];
    f_o.opc = body_i[POS_OPC +: OPC_W];
    f_o.rt  = body_i[POS_RT  +: REG_W];
  end

  // narrow mode: destination doubles as second source
  assign dest_o    = mode16_i ? f_o.rt : f_o.rb;
  assign page_o    = mode16_i & body_i[POS_PAGE];
  assign ra_zero_o = (f_o.ra == '0);
endmodule

// File: rtl/c16_op_table.sv
module c16_op_table
  import c16_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic             page_i,
  input  logic             ra_zero_i,
  input  logic             mode16_i,
  output uop_e             uop_o,
  output logic             reserved_o
);
  always_comb begin
    uop_o      = UOP_NONE;
    reserved_o = 1'b0;
    case (opc_i)
      4'b0100: begin
        if (page_i)         uop_o = UOP_SLD;
        else if (ra_zero_i) uop_o = UOP_CBANK;
        else                uop_o = UOP_ADD;
      end
      4'b0101: begin
        if (page_i) uop_o = ra_zero_i ? UOP_SRAD : UOP_SRD;
        else        uop_o = UOP_SUB;
      end
      4'b0110: uop_o = page_i ? UOP_CMPW : UOP_CMPL;
      4'b0111: begin
        if (page_i) begin
          if (ra_zero_i) uop_o = UOP_FABS;
          else           reserved_o = 1'b1;
        end else begin
          uop_o = ra_zero_i ? UOP_FNEG : UOP_FSUB;
        end
      end
      4'b1000: begin
        if (page_i) begin
          if (ra_zero_i) uop_o = UOP_EXTSB;
          else           reserved_o = 1'b1;
        end else if (!ra_zero_i) uop_o = UOP_AND;
        else if (mode16_i)       uop_o = UOP_EXTSW;
        else                     reserved_o = 1'b1;
      end
      4'b1001: begin
        if (page_i) begin
          if (ra_zero_i) uop_o = UOP_CNTTZ;
          else           reserved_o = 1'b1;
        end else if (!ra_zero_i) uop_o = UOP_NAND;
        else if (mode16_i)       uop_o = UOP_CNTLZ;
        else                     reserved_o = 1'b1;
      end
      4'b1010: begin
        if (page_i) begin
          if (ra_zero_i) reserved_o = 1'b1;
          else           uop_o = UOP_XOR;
        end else if (!ra_zero_i) uop_o = UOP_OR;
        else if (mode16_i)       uop_o = UOP_POPCNT;
        else                     reserved_o = 1'b1;
      end
      4'b1011: begin
        if (page_i)         uop_o = ra_zero_i ? UOP_EXTSH : UOP_EQV;
        else if (ra_zero_i) uop_o = UOP_NOT;
        else                uop_o = mode16_i ? UOP_NOR : UOP_MR;
      end
      4'b1100: begin
        if (page_i) begin
          if (ra_zero_i) uop_o = UOP_FMR;
          else           reserved_o = 1'b1;
        end else begin
          if (ra_zero_i) reserved_o = 1'b1;
          else           uop_o = UOP_FADD;
        end
      end
      4'b1101: begin
        if (ra_zero_i) reserved_o = 1'b1;
        else           uop_o = page_i ? UOP_FDIV : UOP_FMUL;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({opc_i, page_i, ra_zero_i, mode16_i})) begin
      // R4: the move form exists only in the narrow mode
      a_r4_mr_narrow_only: assert ((uop_o != UOP_MR) || !mode16_i)
        else $error("mr decoded in 16-bit mode");
      // R11: a reserved slot carries no operation
      a_r11_reserved_no_op: assert (!reserved_o || (uop_o == UOP_NONE))
        else $error("reserved slot produced an operation");
    end
  end
endmodule

// File: rtl/c16_special.sv
module c16_special
  import c16_alu_pkg::*;
(
  input  logic              mode16_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              all_zero_o,
  output logic              nop_o
);
  logic mid_zero;

  assign mid_zero   = (insn_i[INSN_W-2:1] == '0);
  assign all_zero_o = mid_zero & ~insn_i[0] & ~insn_i[INSN_W-1];
  // narrow nop needs N clear; 16-bit nops allow N set with or without M
  assign nop_o = mid_zero & ~all_zero_o & (mode16_i | ~insn_i[INSN_W-1]);
endmodule

// File: rtl/c16_attr.sv
module c16_attr
  import c16_alu_pkg::*;
(
  input  uop_e  uop_i,
  input  logic  ra_zero_i,
  output crt_e  crt_o,
  output logic  zero_a_o
);
  always_comb begin
    case (uop_i)
      UOP_SUB, UOP_CMPL, UOP_CMPW,
      UOP_SLD, UOP_SRD, UOP_SRAD:          crt_o = CRT_CR0;
      UOP_FSUB, UOP_FNEG, UOP_FABS, UOP_FMR: crt_o = CRT_CR1;
      default:                             crt_o = CRT_NONE;
    endcase
  end

  always_comb begin
    case (uop_i)
      UOP_NONE, UOP_SRAD, UOP_CBANK: zero_a_o = 1'b0;
      default:                       zero_a_o = ra_zero_i;
    endcase
  end
endmodule

// File: rtl/c16_alu_decode.sv
module c16_alu_decode
  import c16_alu_pkg::*;
(
  input  logic        mode16,
  input  logic [15:0] insn,
  output logic [4:0]  uop,
  output logic [2:0]  rd,
  output logic [2:0]  ra,
  output logic [2:0]  rb,
  output logic        zero_a,
  output logic [1:0]  cr_tgt,
  output logic        illegal,
  output logic        nop
);
  fields_t          fld;
  logic [REG_W-1:0] dest;
  logic             page, ra_zero, reserved, all_zero;
  uop_e             raw_uop, fin_uop;
  crt_e             crt;

  c16_fields u_fields (
    .mode16_i (mode16),
    .body_i   (insn[INSN_W-2:1]),
    .f_o      (fld),
    .dest_o   (dest),
    .page_o   (page),
    .ra_zero_o(ra_zero)
  );

  c16_op_table u_table (
    .opc_i     (fld.opc),
    .page_i    (page),
    .ra_zero_i (ra_zero),
    .mode16_i  (mode16),
    .uop_o     (raw_uop),
    .reserved_o(reserved)
  );

  c16_special u_special (
    .mode16_i  (mode16),
    .insn_i    (insn),
    .all_zero_o(all_zero),
    .nop_o     (nop)
  );

  assign illegal = all_zero | reserved;
  assign fin_uop = illegal ? UOP_NONE : raw_uop;

  c16_attr u_attr (
    .uop_i    (fin_uop),
    .ra_zero_i(ra_zero),
    .crt_o    (crt),
    .zero_a_o (zero_a)
  );

  assign uop    = fin_uop;
  assign cr_tgt = crt;
  assign rd     = dest;
  assign rb     = fld.rb;
  // shift-right-algebraic takes its source from the destination field
  assign ra     = (fin_uop == UOP_SRAD) ? fld.rt : fld.ra;

  always_comb begin
    if (!$isunknown({mode16, insn})) begin
      a_r11_illegal_quiet: assert (!illegal || (uop == '0 && cr_tgt == '0 && !zero_a))
        else $error("illegal word carries an operation");
      a_r12_nop_legal: assert (!nop || (!illegal && uop == '0))
        else $error("nop flagged illegal or with an operation");
      a_r9_zero_needs_ra0: assert (!zero_a || (insn[3:1] == 3'd0))
        else $error("zero operand with nonzero RA");
      a_r10_cr_code: assert (cr_tgt != 2'd3)
        else $error("undefined CR target code");
      a_r6_narrow_no_page1: assert (mode16 || !(fin_uop inside {UOP_CMPW, UOP_SLD,
          UOP_SRD, UOP_SRAD, UOP_XOR, UOP_EQV, UOP_EXTSB, UOP_EXTSH, UOP_CNTTZ,
          UOP_FDIV, UOP_FABS, UOP_FMR, UOP_EXTSW, UOP_CNTLZ, UOP_POPCNT}))
        else $error("16-bit-only operation decoded in narrow mode");
    end
  end
endmodule

// File: tb/c16_alu_decode_bench.sv
module c16_alu_decode_bench;
  logic        clk;
  logic        mode16;
  logic [15:0] insn;
  logic [4:0]  uop;
  logic [2:0]  rd, ra, rb;
  logic        zero_a, illegal, nop;
  logic [1:0]  cr_tgt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  c16_alu_decode u_c16_alu_decode (
    .mode16(mode16), .insn(insn), .uop(uop), .rd(rd), .ra(ra), .rb(rb),
    .zero_a(zero_a), .cr_tgt(cr_tgt), .illegal(illegal), .nop(nop)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       md;
    logic       n;
    logic       pg;
    logic [2:0] rt;
    logic [3:0] opc;
    logic [2:0] rb;
    logic [2:0] ra;
    logic       m;
    logic [4:0] uop;
    logic       za;
    logic [1:0] cr;
    logic       ill;
    logic       nop;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 46;
  //                md n pg rt opc rb ra m  uop za cr il np req
  localparam vec_t VECS [NV] = '{
    '{1,0,0,5, 4,2,3,1,  1,0,0,0,0, 3},  // R3 add
    '{0,1,0,7, 4,2,3,0,  1,0,0,0,0, 3},  // R3 add, narrow rd = RB
    '{1,0,0,1, 4,4,0,1, 29,0,0,0,0, 3},  // R3 bank-select
    '{1,0,0,6, 5,3,0,0,  2,1,1,0,0, 3},  // R3 neg form of sub
    '{0,0,0,0, 5,5,4,1,  2,0,1,0,0, 3},  // R3 sub narrow
    '{1,0,0,2, 6,1,0,1,  3,1,1,0,0, 3},  // R3 cmpl against zero
    '{1,0,1,0, 6,1,3,1,  4,0,1,0,0, 7},  // R7 cmpw
    '{1,0,1,4, 4,5,6,1,  5,0,1,0,0, 7},  // R7 sld
    '{1,0,1,3, 5,2,0,1,  7,0,1,0,0, 7},  // R7 srad
    '{1,0,1,3, 5,2,1,1,  6,0,1,0,0, 7},  // R7 srd
    '{1,0,0,7,11,1,2,1, 11,0,0,0,0, 4},  // R4 nor
    '{0,0,0,7,11,1,2,1, 12,0,0,0,0, 4},  // R4 mr
    '{0,0,0,0,11,6,0,1, 13,1,0,0,0, 5},  // R5 not
    '{1,0,0,1, 8,2,0,1, 14,1,0,0,0, 5},  // R5 extsw
    '{0,0,0,0, 8,2,0,1,  0,0,0,1,0, 5},  // R5 extsw narrow illegal
    '{0,0,0,0, 9,2,0,1,  0,0,0,1,0, 5},  // R5 cntlz narrow illegal
    '{0,0,0,0,10,2,0,1,  0,0,0,1,0, 5},  // R5 popcnt narrow illegal
    '{1,0,0,0, 9,2,0,1, 17,1,0,0,0, 5},  // R5 cntlz
    '{1,0,0,0,10,2,0,1, 19,1,0,0,0, 5},  // R5 popcnt
    '{1,0,1,2,10,3,5,1, 20,0,0,0,0, 6},  // R6 xor
    '{1,0,1,2,11,3,5,1, 21,0,0,0,0, 6},  // R6 eqv
    '{1,0,1,2, 8,3,0,1, 15,1,0,0,0, 6},  // R6 extsb
    '{1,0,1,2, 9,3,0,1, 18,1,0,0,0, 6},  // R6 cnttz
    '{1,0,1,2,11,3,0,1, 16,1,0,0,0, 6},  // R6 extsh
    '{1,0,1,2, 8,3,5,1,  0,0,0,1,0, 6},  // R6 reserved
    '{1,0,1,2,10,3,0,1,  0,0,0,1,0, 6},  // R6 reserved
    '{0,0,1,2,10,3,5,1, 10,0,0,0,0, 6},  // R6 page bit ignored narrow
    '{1,0,0,2, 8,3,5,1,  8,0,0,0,0, 4},  // R4 and
    '{0,0,0,2, 9,3,5,1,  9,0,0,0,0, 4},  // R4 nand
    '{1,0,0,1,12,2,3,1, 22,0,0,0,0, 8},  // R8 fadd
    '{1,0,0,1,13,2,3,1, 24,0,0,0,0, 8},  // R8 fmul
    '{1,0,0,1, 7,2,3,1, 23,0,2,0,0, 8},  // R8 fsub
    '{1,0,0,1, 7,2,0,1, 26,1,2,0,0, 8},  // R8 fneg
    '{1,0,1,1,13,2,3,1, 25,0,0,0,0, 8},  // R8 fdiv
    '{1,0,1,1, 7,2,0,1, 27,1,2,0,0, 8},  // R8 fabs
    '{1,0,1,1,12,2,0,1, 28,1,2,0,0, 8},  // R8 fmr
    '{1,0,0,1,12,2,0,1,  0,0,0,1,0, 8},  // R8 reserved
    '{0,0,1,1,13,2,3,1, 24,0,0,0,0, 8},  // R8 no fdiv narrow
    '{1,0,1,1, 7,2,3,1,  0,0,0,1,0, 8},  // R8 reserved
    '{1,0,0,0, 0,0,0,0,  0,0,0,1,0,11},  // R11 all zero 16-bit
    '{0,0,0,0, 0,0,0,0,  0,0,0,1,0,11},  // R11 all zero narrow
    '{0,0,0,0, 0,0,0,1,  0,0,0,0,1,12},  // R12 nop narrow
    '{1,1,0,0, 0,0,0,0,  0,0,0,0,1,12},  // R12 nop N set
    '{0,1,0,0, 0,0,0,0,  0,0,0,0,0,13},  // R13 N ignored narrow
    '{1,1,0,0, 0,0,0,1,  0,0,0,0,1,12},  // R12 nop N and M
    '{1,0,0,3,14,2,2,1,  0,0,0,0,0,13}   // R13 out-of-scope major
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic md, input logic [15:0] w);
    @(negedge clk);
    mode16 = md;
    insn   = w;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mode16 = 1'b0;
    insn   = 16'h0;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [2:0] e_rd, e_ra;
      string rq;
      v = VECS[i];
      drive(v.md, {v.n, v.pg, v.rt, v.opc, v.rb, v.ra, v.m});
      rq = $sformatf("R%0d", v.req);
      e_rd = v.md ? v.rt : v.rb;                 // R1
      e_ra = (v.uop == 5'd7) ? v.rt : v.ra;      // R1 srad exception
      chk(uop == v.uop, {rq, "/R2"}, $sformatf("uop vec %0d", i), uop, v.uop);
      chk(rd == e_rd && ra == e_ra && rb == v.rb, "R1",
          $sformatf("regs vec %0d", i), {rd, ra, rb}, {e_rd, e_ra, v.rb});
      chk(zero_a == v.za, "R9", $sformatf("zero_a vec %0d", i), zero_a, v.za);
      chk(cr_tgt == v.cr, "R10", $sformatf("cr vec %0d", i), cr_tgt, v.cr);
      chk(illegal == v.ill, "R11", $sformatf("illegal vec %0d", i), illegal, v.ill);
      chk(nop == v.nop, "R12", $sformatf("nop vec %0d", i), nop, v.nop);
    end

    // R12: 0x8001 in narrow mode is neither nop nor illegal
    drive(1'b0, 16'h8001);
    chk(nop == 1'b0 && illegal == 1'b0, "R12", "0x8001 narrow", {nop, illegal}, 0);

    // R13: upper five bits have no effect in narrow mode
    for (int lo = 2; lo < 2048; lo += 37) begin
      logic [4:0] r_uop;
      logic [8:0] r_regs;
      logic [4:0] r_flags;
      drive(1'b0, {5'd0, 11'(lo)});
      r_uop   = uop;
      r_regs  = {rd, ra, rb};
      r_flags = {zero_a, cr_tgt, illegal, nop};
      for (int hi = 1; hi < 32; hi++) begin
        drive(1'b0, {5'(hi), 11'(lo)});
        chk(uop == r_uop && {rd, ra, rb} == r_regs &&
            {zero_a, cr_tgt, illegal, nop} == r_flags, "R13",
            $sformatf("narrow upper bits lo=%0d hi=%0d", lo, hi),
            {uop, rd, ra, rb, zero_a, cr_tgt, illegal, nop},
            {r_uop, r_regs, r_flags});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule